// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a synchronous, single-request port to an asynchronous 128K x 16 fast-page-mode DRAM. A request carries a 17-bit word address, a write flag, 16 bits of write data and two byte enables. The controller splits the address into a 9-bit row and an 8-bit column and presents both on a shared 9-bit address bus. It sequences the row strobe, the two byte-lane column strobes, write enable and output enable. Every interval is a whole number of clock cycles, derived from nanosecond parameters by rounding up. Read data comes back with a one-cycle valid pulse.

After an access the row stays open. A following request to the same row runs as a column-only page cycle, so it skips the row strobe and the precharge. The row is closed in three cases: a request to another row arrives, the refresh grant input rises, or the row-strobe-low time approaches its permitted maximum. After a close the row strobe is held high for the precharge count before the next activate. While refresh is granted, the controller keeps every strobe high and accepts nothing, so an external refresh engine can use the memory.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: At the clock where `dram_ras_n` falls, `dram_a` carries the row, `req_addr[16:8]`. At the clock where a column strobe falls, `dram_a` carries the column, `{1'b0, req_addr[7:0]}`.
- R2: On a write, only the lanes whose byte enable is 1 drop their strobe. `req_be[0]` maps to `dram_lcas_n` and data bits 7:0; `req_be[1]` maps to `dram_ucas_n` and bits 15:8. On a read, both strobes fall in the same cycle, whatever the byte enables are.
- R3: A write drops `dram_we_n` at least one cycle before any column strobe falls. `dram_oe_n` stays high while `dram_we_n` is low, and `dram_dq_oe` is 1 only while `dram_oe_n` is high.
- R4: `dram_oe_n` is low only during the column strobe phase of a read. `rd_data` holds `dram_dq_in` as sampled on the last strobe-low cycle, and `rd_valid` is high for exactly one cycle per read.
- R5: A request to the row that is already open runs with no new fall of `dram_ras_n`.
- R6: A request to a different row raises `dram_ras_n`. The strobe stays high for at least max(precharge, random cycle - row-low) cycles, which is 5 at the default parameters, and then the new row is activated.
- R7: Every low period of `dram_ras_n` lasts at least the row-low minimum, 6 cycles at the defaults, and never exceeds the page-mode maximum. An open row left idle is closed before that maximum is reached.
- R8: While `ref_grant` is 1, the open row is closed, all strobes stay high, `req_ready` is 0 and a pending `req_valid` causes no DRAM cycle.
- R9: Out of reset, all strobes, `dram_we_n` and `dram_oe_n` are high, `req_ready` is 1, and `busy` and `rd_valid` are 0. `busy` is 1 from acceptance until the access completes, and `req_ready` is never 1 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 17 | Word address, row in 16:8, column in 7:0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 low lane, bit 1 high lane |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data |
| busy | output | 1 | An access or row close is in progress |
| ref_grant | input | 1 | Refresh owns the memory; close row and hold off |
| dram_a | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Low-lane column strobe, active low |
| dram_ucas_n | output | 1 | High-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven towards the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
The assertions assume that reset is held low from time zero and that `ref_grant` and the request inputs change only between clock edges. They also assume that `dram_dq_in` is stable during the last cycle of a read strobe phase. The bench meets these conditions in several ways. It drives every input on the falling clock edge. Its memory model updates its data output on the falling edge as well, from the strobes it sees at that point. It keeps one request in flight at a time and lowers `req_valid` right after acceptance. For the timeout case it shortens the page-mode limit parameter, so an idle row reaches that limit within a few hundred cycles.

// File: rtl/fpm_ctrl_pkg.sv
// Shared types and constant helpers for the fast-page DRAM controller.
// Assumes: timing parameters are positive nanosecond integers.
package fpm_ctrl_pkg;

    // Controller phases; the row strobe is high only in ST_IDLE and ST_PRECH.
    typedef enum logic [2:0] {
        ST_IDLE,    // row closed, precharged
        ST_ACT,     // row strobe low, row then column on address pins
        ST_STROBE,  // column strobe(s) low
        ST_GAP,     // column precharge after a strobe
        ST_OPEN,    // row open, waiting for a request
        ST_COLSET,  // page hit: column and write enable set up
        ST_HOLD,    // waiting for minimum row-low time before closing
        ST_PRECH    // row strobe high, precharging
    } fpm_state_e;

    // Nanoseconds to cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_req_reg.sv
// Holds the request being served and compares an incoming row with it.
// Assumes: load is asserted only on an accepted handshake.
module fpm_req_reg #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2,
    parameter int ROW_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [BE_W-1:0]   in_be,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_write,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [BE_W-1:0]   cur_be,
    output logic              in_hit
);

    // Capture the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_write <= 1'b0;
            cur_wdata <= '0;
            cur_be    <= '0;
        end else if (load) begin
            cur_addr  <= in_addr;
            cur_write <= in_write;
            cur_wdata <= in_wdata;
            cur_be    <= in_be;
        end
    end

    // Incoming request targets the row held in the register.
    always_comb in_hit = (in_addr[ADDR_W-1 -: ROW_W] == cur_addr[ADDR_W-1 -: ROW_W]);

endmodule

// File: rtl/fpm_seq.sv
// Phase sequencer: walks activate, strobe, gap, open, hold and precharge,
// counts phase lengths and row-low time, and owns the request handshake.
// Assumes: every length parameter is at least 1; RAS_LIM < RAS_MAX.
module fpm_seq
    import fpm_ctrl_pkg::*;
#(
    parameter int ACT_LEN = 2,
    parameter int STB_LEN = 2,
    parameter int GAP_LEN = 1,
    parameter int PRE_LEN = 5,
    parameter int RAH_LEN = 1,
    parameter int RAS_MIN = 6,
    parameter int RAS_LIM = 100,
    parameter int RAS_MAX = 110
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_hit,
    input  logic       ref_grant,
    output logic       req_ready,
    output logic       busy,
    output logic       load,
    output fpm_state_e state,
    output logic       row_phase,
    output logic       strobe_last
);

    localparam int PH_MAX = imax(imax(ACT_LEN, STB_LEN), imax(GAP_LEN, PRE_LEN));
    localparam int CW     = $clog2(PH_MAX + 1) + 1;
    localparam int RW     = $clog2(RAS_MAX + 1) + 1;
    localparam logic [CW-1:0] ACT_LAST = CW'(ACT_LEN - 1);
    localparam logic [CW-1:0] STB_LAST = CW'(STB_LEN - 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_LEN - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRE_LEN - 1);
    localparam logic [CW-1:0] RAH_V    = CW'(RAH_LEN);
    localparam logic [RW-1:0] RMIN_M1  = RW'(RAS_MIN - 1);
    localparam logic [RW-1:0] RLIM_V   = RW'(RAS_LIM);

    fpm_state_e      st_q, st_d;
    logic [CW-1:0]   ph_q, ph_d;
    logic [RW-1:0]   ras_q, ras_d;
    logic            pend_q, pend_d;
    logic            row_closed, timeout, fire, ph_last;

    // Row state and page-time limit.
    always_comb begin
        row_closed = (st_q == ST_IDLE) || (st_q == ST_PRECH);
        timeout    = (ras_q >= RLIM_V);
    end

    // Handshake and busy flag.
    always_comb begin
        req_ready = !ref_grant && !pend_q &&
                    ((st_q == ST_IDLE) || ((st_q == ST_OPEN) && !timeout));
        fire      = req_valid && req_ready;
        load      = fire;
        busy      = pend_q || !((st_q == ST_IDLE) || (st_q == ST_OPEN));
    end

    // Last cycle of the current timed phase.
    always_comb begin
        unique case (st_q)
            ST_ACT:    ph_last = (ph_q == ACT_LAST);
            ST_STROBE: ph_last = (ph_q == STB_LAST);
            ST_GAP:    ph_last = (ph_q == GAP_LAST);
            ST_PRECH:  ph_last = (ph_q == PRE_LAST);
            default:   ph_last = 1'b1;
        endcase
    end

    // Next phase selection.
    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!ref_grant && pend_q) begin
                    st_d   = ST_ACT;
                    pend_d = 1'b0;
                end else if (fire) begin
                    st_d = ST_ACT;
                end
            end
            ST_ACT:    if (ph_last) st_d = ST_STROBE;
            ST_STROBE: if (ph_last) st_d = ST_GAP;
            ST_GAP:    if (ph_last) st_d = ST_OPEN;
            ST_OPEN: begin
                if (ref_grant || timeout) begin
                    st_d = ST_HOLD;
                end else if (fire) begin
                    if (req_hit) begin
                        st_d = ST_COLSET;
                    end else begin
                        st_d   = ST_HOLD;
                        pend_d = 1'b1;
                    end
                end
            end
            ST_COLSET: st_d = ST_STROBE;
            ST_HOLD:   if (ras_q >= RMIN_M1) st_d = ST_PRECH;
            ST_PRECH:  if (ph_last) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Phase counter restarts on every phase change and saturates.
    always_comb begin
        if (st_d != st_q)  ph_d = '0;
        else if (&ph_q)    ph_d = ph_q;
        else               ph_d = ph_q + 1'b1;
    end

    // Row-low counter: cycles spent with the row strobe low, minus one.
    always_comb begin
        if (row_closed)    ras_d = '0;
        else if (&ras_q)   ras_d = ras_q;
        else               ras_d = ras_q + 1'b1;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ph_q   <= '0;
            ras_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ph_q   <= ph_d;
            ras_q  <= ras_d;
            pend_q <= pend_d;
        end
    end

    // Phase outputs for the pin driver.
    always_comb begin
        state       = st_q;
        row_phase   = (st_q == ST_ACT) && (ph_q < RAH_V);
        strobe_last = (st_q == ST_STROBE) && (ph_q == STB_LAST);
    end

endmodule

// File: rtl/fpm_pin_drv.sv
// Decodes the phase into DRAM pin levels and captures read data.
// Assumes: memory data is stable on the last strobe-low cycle of a read.
module fpm_pin_drv
    import fpm_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2,
    parameter int ROW_W  = 9,
    parameter int PIN_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fpm_state_e        state,
    input  logic              row_phase,
    input  logic              strobe_last,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_write,
    input  logic [DATA_W-1:0] cur_wdata,
    input  logic [BE_W-1:0]   cur_be,
    input  logic [DATA_W-1:0] dq_in,
    output logic [PIN_W-1:0]  a_pins,
    output logic              ras_n,
    output logic [BE_W-1:0]   cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int COL_W = ADDR_W - ROW_W;

    logic use_col, strobing, wr_window;

    // Phase decode shared by the pins.
    always_comb begin
        use_col   = ((state == ST_ACT) && !row_phase) || (state == ST_COLSET) ||
                    (state == ST_STROBE) || (state == ST_GAP);
        strobing  = (state == ST_STROBE);
        wr_window = cur_write &&
                    ((state == ST_ACT) || (state == ST_COLSET) || (state == ST_STROBE));
    end

    // Address multiplexer: row first, column once the row hold has elapsed.
    always_comb begin
        if (use_col) a_pins = PIN_W'(cur_addr[COL_W-1:0]);
        else         a_pins = PIN_W'(cur_addr[ADDR_W-1 -: ROW_W]);
    end

    // Row strobe, write enable, output enable and data drive.
    always_comb begin
        ras_n  = (state == ST_IDLE) || (state == ST_PRECH);
        we_n   = !wr_window;
        oe_n   = !(strobing && !cur_write);
        dq_oe  = wr_window;
        dq_out = cur_wdata;
    end

    // One column strobe per byte lane; reads drop all lanes.
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        always_comb cas_n[g] = !(strobing && (!cur_write || cur_be[g]));
    end

    // Read capture on the last strobe-low cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= strobe_last && !cur_write;
            if (strobe_last && !cur_write) rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/fpm_dram_ctrl.sv
// Top: fast-page-mode DRAM controller for a 128K x 16 part. Converts the
// nanosecond timing parameters to cycle counts and wires the request
// register, the phase sequencer and the pin driver.
// Assumes: one request in flight; refresh is done elsewhere under ref_grant.
module fpm_dram_ctrl
    import fpm_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 16,
    parameter int ROW_W      = 9,
    parameter int CLK_NS     = 10,
    parameter int T_RAS_NS   = 60,
    parameter int T_RP_NS    = 40,
    parameter int T_RC_NS    = 110,
    parameter int T_RCD_NS   = 20,
    parameter int T_CAS_NS   = 15,
    parameter int T_CAC_NS   = 15,
    parameter int T_CP_NS    = 10,
    parameter int T_PC_NS    = 40,
    parameter int T_RAH_NS   = 10,
    parameter int T_CAH_NS   = 15,
    parameter int T_RASP_NS  = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    input  logic              ref_grant,
    output logic [8:0]        dram_a,
    output logic              dram_ras_n,
    output logic              dram_lcas_n,
    output logic              dram_ucas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);

    localparam int BE_W     = DATA_W / 8;
    localparam int COL_W    = ADDR_W - ROW_W;
    localparam int PIN_W    = imax(ROW_W, COL_W);
    localparam int RAS_CYC  = ns_to_cyc(T_RAS_NS, CLK_NS);
    localparam int RP_CYC   = ns_to_cyc(T_RP_NS, CLK_NS);
    localparam int RC_CYC   = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int RCD_CYC  = ns_to_cyc(T_RCD_NS, CLK_NS);
    localparam int CAS_CYC  = ns_to_cyc(T_CAS_NS, CLK_NS);
    localparam int CAC_CYC  = ns_to_cyc(T_CAC_NS, CLK_NS);
    localparam int CP_CYC   = ns_to_cyc(T_CP_NS, CLK_NS);
    localparam int PC_CYC   = ns_to_cyc(T_PC_NS, CLK_NS);
    localparam int RAH_CYC  = ns_to_cyc(T_RAH_NS, CLK_NS);
    localparam int CAH_CYC  = ns_to_cyc(T_CAH_NS, CLK_NS);
    localparam int RASP_CYC = ns_to_cyc(T_RASP_NS, CLK_NS);
    // Activate long enough for row hold plus one column set-up cycle.
    localparam int ACT_LEN  = imax(RCD_CYC, RAH_CYC + 1);
    localparam int STB_LEN  = imax(imax(CAS_CYC, CAC_CYC), CAH_CYC);
    // Gap plus the column set-up cycle cover both column precharge and page cycle.
    localparam int GAP_LEN  = imax(1, imax(CP_CYC, PC_CYC - STB_LEN) - 1);
    localparam int PRE_LEN  = imax(RP_CYC, RC_CYC - RAS_CYC);
    // Stop accepting page hits early enough that one more never overruns.
    localparam int RAS_LIM  = RASP_CYC - (STB_LEN + GAP_LEN + 3);

    logic [ADDR_W-1:0] cur_addr;
    logic              cur_write;
    logic [DATA_W-1:0] cur_wdata;
    logic [BE_W-1:0]   cur_be;
    logic              in_hit, load, row_phase, strobe_last;
    logic [BE_W-1:0]   cas_n;
    logic [PIN_W-1:0]  a_pins;
    fpm_state_e        state;

    fpm_req_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .ROW_W(ROW_W)
    ) u_req (
        .clk(clk), .rst_n(rst_n), .load(load),
        .in_addr(req_addr), .in_write(req_write), .in_wdata(req_wdata), .in_be(req_be),
        .cur_addr(cur_addr), .cur_write(cur_write), .cur_wdata(cur_wdata),
        .cur_be(cur_be), .in_hit(in_hit)
    );

    fpm_seq #(
        .ACT_LEN(ACT_LEN), .STB_LEN(STB_LEN), .GAP_LEN(GAP_LEN), .PRE_LEN(PRE_LEN),
        .RAH_LEN(RAH_CYC), .RAS_MIN(RAS_CYC), .RAS_LIM(RAS_LIM), .RAS_MAX(RASP_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(in_hit),
        .ref_grant(ref_grant), .req_ready(req_ready), .busy(busy), .load(load),
        .state(state), .row_phase(row_phase), .strobe_last(strobe_last)
    );

    fpm_pin_drv #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .ROW_W(ROW_W), .PIN_W(PIN_W)
    ) u_pins (
        .clk(clk), .rst_n(rst_n), .state(state), .row_phase(row_phase),
        .strobe_last(strobe_last), .cur_addr(cur_addr), .cur_write(cur_write),
        .cur_wdata(cur_wdata), .cur_be(cur_be), .dq_in(dram_dq_in),
        .a_pins(a_pins), .ras_n(dram_ras_n), .cas_n(cas_n), .we_n(dram_we_n),
        .oe_n(dram_oe_n), .dq_out(dram_dq_out), .dq_oe(dram_dq_oe),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Lane 0 is the low byte, lane 1 the high byte.
    always_comb begin
        dram_lcas_n = cas_n[0];
        dram_ucas_n = cas_n[1];
        dram_a      = 9'(a_pins);
    end

endmodule

// File: rtl/fpm_ctrl_chk.sv
// Protocol checker bound to the controller top; watches pins and handshake.
// Assumes: reset low from time zero, inputs change between clock edges.
module fpm_ctrl_chk #(
    parameter int RAS_MIN = 6,
    parameter int RP_MIN  = 5,
    parameter int RAS_MAX = 10000
) (
    input logic clk,
    input logic rst_n,
    input logic dram_ras_n,
    input logic dram_lcas_n,
    input logic dram_ucas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe,
    input logic rd_valid,
    input logic req_ready,
    input logic busy,
    input logic ref_grant
);

    localparam int KW = $clog2(RAS_MAX + 2) + 1;
    localparam logic [KW-1:0] RMIN_V = KW'(RAS_MIN);
    localparam logic [KW-1:0] RPMN_V = KW'(RP_MIN);
    localparam logic [KW-1:0] RMAX_V = KW'(RAS_MAX);

    logic [KW-1:0] lo_run, hi_run;

    // Lengths of the current low and high runs of the row strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run <= '0;
            hi_run <= '1;
        end else if (dram_ras_n) begin
            lo_run <= '0;
            hi_run <= (&hi_run) ? hi_run : hi_run + 1'b1;
        end else begin
            hi_run <= '0;
            lo_run <= (&lo_run) ? lo_run : lo_run + 1'b1;
        end
    end

    // R7
    ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (lo_run >= RMIN_V));
    // R7
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (lo_run < RMAX_V));
    // R6
    prech_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_run >= RPMN_V));
    // R1
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_lcas_n || !dram_ucas_n) |-> !dram_ras_n);
    // R3
    early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0));
    // R3
    wr_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);
    // R3
    dq_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n);
    // R2
    rd_both_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (dram_lcas_n == dram_ucas_n));
    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy);
    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_grant && $past(ref_grant)) |-> (dram_lcas_n && dram_ucas_n && !req_ready));

endmodule

bind fpm_dram_ctrl fpm_ctrl_chk #(
    .RAS_MIN(RAS_CYC), .RP_MIN(PRE_LEN), .RAS_MAX(RASP_CYC)
) u_fpm_chk (
    .clk(clk), .rst_n(rst_n), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
    .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_oe(dram_dq_oe), .rd_valid(rd_valid), .req_ready(req_ready),
    .busy(busy), .ref_grant(ref_grant)
);

// File: tb/test_fpm_dram_ctrl.sv
// Directed bench with a behavioural DRAM model sampled on the falling clock edge.
module test_fpm_dram_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int RASP_NS    = 2000;   // 200 cycles page limit for the timeout test

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [16:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        ref_grant = 1'b0;
    logic        req_ready, rd_valid, busy;
    logic [15:0] rd_data;
    logic [8:0]  dram_a;
    logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] dram_dq_out;
    logic [15:0] dram_dq_in = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpm_dram_ctrl #(.CLK_NS(CLK_PERIOD), .T_RASP_NS(RASP_NS)) i_fpm_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .ref_grant(ref_grant), .dram_a(dram_a), .dram_ras_n(dram_ras_n),
        .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    // ---------------- DRAM model ----------------
    logic [15:0] mem [int];
    logic [8:0]  m_row = '0, m_col = '0;
    logic        p_ras = 1'b1, p_l = 1'b1, p_u = 1'b1, p_we = 1'b1;
    int act_cnt = 0, lo_len = 0, hi_len = 1000;
    int min_lo = 1000, max_lo = 0, min_hi = 1000;
    int bad_ew = 0, bad_oe = 0, bad_split = 0;

    function automatic logic [15:0] rdmem(input logic [16:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 16'h0000;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (!dram_ras_n && p_ras) begin
                act_cnt++;
                m_row = dram_a;
                if (hi_len < min_hi) min_hi = hi_len;
            end
            if (dram_ras_n && !p_ras) begin
                if (lo_len < min_lo) min_lo = lo_len;
                if (lo_len > max_lo) max_lo = lo_len;
            end
            if (!dram_ras_n) begin lo_len++; hi_len = 0; end
            else begin hi_len++; lo_len = 0; end
            if ((!dram_lcas_n && p_l) || (!dram_ucas_n && p_u)) begin
                m_col = dram_a;
                if (!dram_we_n) begin
                    logic [15:0] w;
                    if (!p_we) ; else bad_ew++;
                    w = rdmem({m_row, m_col[7:0]});
                    if (!dram_lcas_n) w[7:0]  = dram_dq_out[7:0];
                    if (!dram_ucas_n) w[15:8] = dram_dq_out[15:8];
                    mem[int'({m_row, m_col[7:0]})] = w;
                end
            end
            if (!dram_we_n && !dram_oe_n) bad_oe++;
            if (!dram_oe_n && (dram_lcas_n != dram_ucas_n)) bad_split++;
            if (!dram_oe_n) dram_dq_in = rdmem({m_row, m_col[7:0]});
            else            dram_dq_in = 16'hDEAD;
        end
        p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n; p_we = dram_we_n;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [16:0] a, input logic wr, input logic [15:0] d,
                         input logic [1:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
        issue(a, 1'b1, d, be);
        repeat (6) @(negedge clk);
    endtask

    task automatic do_read(input logic [16:0] a, output logic [15:0] d);
        int k;
        issue(a, 1'b0, 16'h0, 2'b00);
        k = 0;
        while (!rd_valid && k < 40) begin @(negedge clk); k++; end
        d = rd_data;
        check(k < 40, "R4 rd_valid seen", k, 0);
        @(negedge clk);
        check(!rd_valid, "R4 rd_valid one cycle", rd_valid, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check(dram_ras_n && dram_lcas_n && dram_ucas_n, "R9 strobes high", {dram_ras_n, dram_lcas_n, dram_ucas_n}, 7);
        check(dram_we_n && dram_oe_n, "R9 we/oe high", {dram_we_n, dram_oe_n}, 3);
        check(req_ready, "R9 ready", req_ready, 1);
        check(!busy && !rd_valid, "R9 busy/rd_valid low", {busy, rd_valid}, 0);
    endtask

    task automatic t_basic();
        logic [15:0] d;
        do_write(17'h1_2345, 16'hBEEF, 2'b11);
        check(m_row == 9'h123, "R1 row on pins", m_row, 9'h123);
        check(m_col == 9'h045, "R1 column on pins", m_col, 9'h045);
        check(bad_ew == 0, "R3 we before strobe", bad_ew, 0);
        do_read(17'h1_2345, d);
        check(d == 16'hBEEF, "R4 read data", d, 16'hBEEF);
        check(bad_oe == 0, "R3 oe high in write", bad_oe, 0);
    endtask

    task automatic t_lanes();
        logic [15:0] d;
        do_write(17'h1_2345, 16'hAAAA, 2'b11);
        do_write(17'h1_2345, 16'h5555, 2'b01);
        do_read(17'h1_2345, d);
        check(d == 16'hAA55, "R2 low lane only", d, 16'hAA55);
        do_write(17'h1_2345, 16'h1234, 2'b10);
        do_read(17'h1_2345, d);
        check(d == 16'h1255, "R2 high lane only", d, 16'h1255);
        check(bad_split == 0, "R2 read drops both lanes", bad_split, 0);
    endtask

    task automatic t_page();
        logic [15:0] d;
        int a0;
        a0 = act_cnt;
        do_write(17'h1_2300, 16'h0F0F, 2'b11);
        do_read(17'h1_2300, d);
        check(d == 16'h0F0F, "R5 page data", d, 16'h0F0F);
        check(act_cnt == a0, "R5 no new activate", act_cnt, a0);
    endtask

    task automatic t_miss();
        logic [15:0] d;
        int a0;
        a0 = act_cnt;
        do_read(17'h0_0010, d);
        check(d == 16'h0000, "R6 other row data", d, 0);
        do_read(17'h1_2345, d);
        check(d == 16'h1255, "R6 back to first row", d, 16'h1255);
        check(act_cnt == a0 + 2, "R6 activate per miss", act_cnt, a0 + 2);
        check(min_hi >= 5, "R6 precharge length", min_hi, 5);
        check(min_lo >= 6, "R7 row-low minimum", min_lo, 6);
    endtask

    task automatic t_busy();
        logic [15:0] d;
        int k;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 17'h0_4001; req_write = 1'b0; req_be = 2'b11;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy, "R9 busy during access", busy, 1);
        check(!req_ready, "R9 no ready while busy", req_ready, 0);
        k = 0;
        while (!rd_valid && k < 40) begin @(negedge clk); k++; end
        d = rd_data;
        repeat (4) @(negedge clk);
        check(!busy && req_ready, "R9 idle after access", {busy, req_ready}, 1);
        check(d == 16'h0000, "R4 unwritten location", d, 0);
    endtask

    task automatic t_refresh();
        logic [15:0] d;
        int a0;
        check(!dram_ras_n, "R8 row open before grant", dram_ras_n, 0);
        @(negedge clk);
        ref_grant = 1'b1;
        repeat (15) @(negedge clk);
        check(dram_ras_n && dram_lcas_n && dram_ucas_n, "R8 strobes high", {dram_ras_n, dram_lcas_n, dram_ucas_n}, 7);
        a0 = act_cnt;
        req_valid = 1'b1; req_addr = 17'h1_2345; req_write = 1'b0;
        repeat (6) begin
            @(negedge clk);
            check(!req_ready, "R8 ready low in grant", req_ready, 0);
        end
        check(act_cnt == a0, "R8 request ignored", act_cnt, a0);
        req_valid = 1'b0;
        ref_grant = 1'b0;
        do_read(17'h1_2345, d);
        check(d == 16'h1255, "R8 access after grant", d, 16'h1255);
    endtask

    task automatic t_timeout();
        int a0;
        a0 = act_cnt;
        check(!dram_ras_n, "R7 row open at start", dram_ras_n, 0);
        repeat (260) @(negedge clk);
        check(dram_ras_n, "R7 idle row closed", dram_ras_n, 1);
        check(max_lo <= 200, "R7 row-low maximum", max_lo, 200);
        check(act_cnt == a0, "R7 no spurious activate", act_cnt, a0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_lanes();
        t_page();
        t_miss();
        t_busy();
        t_refresh();
        t_timeout();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule